// File: doc/BRIEF.md
# Ping-Pong Buffer Address Sequencer

This block generates memory addresses for one DMA stream that alternates between two buffers. It keeps two base addresses, a programmed beat count and a set of mode bits. Each accepted beat advances the address pointer by the beat size. When the last beat of a block is accepted, the pointer reloads and the beat counter refills. In ping-pong mode the pointer moves to the other buffer's base address, and a one-cycle pulse marks the switch so that a separate interrupt block can raise a transfer-complete event.

Software programs the block through a plain register write port made of a strobe, a select and data. Ping-pong mode, the starting buffer and the beat size are taken only when the stream is started from the stopped state. While the stream runs, software may give a new address to the buffer that is idle, so that buffer is ready for the next switch. A write to the base of the buffer currently in use is dropped and sets a sticky error bit.

The beat interface uses a valid/ready handshake. A beat is accepted on a rising clock edge when `beat_valid` and `beat_ready` are both high. `beat_ready` is high exactly while the stream runs, and this is the only back-pressure the block applies. The requester may hold `beat_valid` high across any number of edges, and each edge where both signals are high counts as one beat.

Top module: `dbuf_addr_seq`

## Requirements
- R1: After reset the stream is stopped, `beat_ready`, `run_o`, `dbuf_on`, `err_o` and `sw_pulse` are 0, `cur_tgt` is 0 and `addr_o` is 0.
- R2: A start request that asks for ping-pong mode (control bit 2) without wrap mode (control bit 1) runs as a single-buffer stream, and `dbuf_on` reads 0.
- R3: A start request that asks for ping-pong mode together with the memory-to-memory bit (control bit 3) runs as a single-buffer stream, and `dbuf_on` reads 0.
- R4: In ping-pong mode, acceptance of the last beat of a block toggles `cur_tgt` and loads `addr_o` with the other buffer's base. This keeps alternating indefinitely.
- R5: On a start with ping-pong mode accepted, control bit 4 selects the first buffer (0 or 1), and `addr_o` shows that buffer's base on the edge of the start write. A single-buffer start always uses buffer 0.
- R6: A control write made while the stream runs changes only the run bit (bit 0). Ping-pong mode, the first-buffer choice, wrap mode and beat size keep their values.
- R7: A base write (select 1 for buffer 0, select 2 for buffer 1) always takes effect while the stream is stopped, and takes effect for the idle buffer while the stream runs. A write to the active buffer's base while the stream runs leaves it unchanged and sets `err_o`.
- R8: `err_o` stays set until a write to select 4 with data bit 0 at 1. A write there with bit 0 at 0 leaves it set.
- R9: Each accepted beat that is not the last of its block adds 1, 2 or 4 to `addr_o`, for a beat-size field (control bits 6:5) of 0, 1 or 2/3. Without an accepted beat, `addr_o` holds.
- R10: `sw_pulse` is high for exactly one cycle per buffer switch. It never fires in single-buffer mode, where a wrap stream reloads the same buffer's base at each block end.
- R11: Without wrap mode, the stream stops itself after the programmed count (select 3) of beats, and `beat_ready` is low whenever the stream is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 base 0, 2 base 1, 3 count, 4 error clear |
| cfg_wdata | input | AW | Register write data |
| beat_valid | input | 1 | A beat is offered |
| beat_ready | output | 1 | A beat can be accepted (stream running) |
| addr_o | output | AW | Address of the current beat |
| cur_tgt | output | 1 | Index of the buffer in use |
| sw_pulse | output | 1 | One-cycle mark of a buffer switch |
| run_o | output | 1 | Stream running |
| dbuf_on | output | 1 | Ping-pong mode active |
| err_o | output | 1 | Sticky blocked-write error |

## Verification
The beat stream is run with a 4-byte step across several full blocks starting on buffer 0. This shows whether switching, counter refill and the per-beat step are right. A second run starts on buffer 1 with a 2-byte step and so tells the first-buffer field apart from a fixed start. Base writes during a run, aimed at the active buffer and at the idle one, show through the next block's addresses whether the block guard acts on the right buffer. Starts with illegal mode combinations and a non-wrap start separate mode rejection, same-buffer reload and the self-stop.

// File: rtl/dbuf_seq_pkg.sv
package dbuf_seq_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE0 = 3'd1,
    SEL_BASE1 = 3'd2,
    SEL_COUNT = 3'd3,
    SEL_ERR   = 3'd4
  } cfg_sel_e;

  localparam int B_RUN   = 0;
  localparam int B_WRAP  = 1;
  localparam int B_PING  = 2;
  localparam int B_M2M   = 3;
  localparam int B_FIRST = 4;
  localparam int B_SZ_LO = 5;

  localparam int NUM_TGT = 2;

  typedef struct packed {
    logic       wrap;
    logic       ping;
    logic       m2m;
    logic [1:0] sz;
  } mode_t;

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dbuf_cfg_regs.sv
module dbuf_cfg_regs
  import dbuf_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [2:0]                     sel,
  input  logic [AW-1:0]                  wdata,
  input  logic                           cur_tgt,
  input  logic                           run_done,
  output logic                           run,
  output mode_t                          mode,
  output logic                           start,
  output logic                           start_tgt,
  output logic [NUM_TGT-1:0][AW-1:0]     base,
  output logic [CW-1:0]                  cnt,
  output logic                           err
);

  logic                 run_q;
  mode_t                mode_q;
  logic [CW-1:0]        cnt_q;
  logic                 err_q;
  logic [NUM_TGT-1:0]   blk_vec;
  logic                 ctrl_wr;
  logic                 ping_ok;

  assign ctrl_wr   = wr && (sel == SEL_CTRL);
  assign ping_ok   = wdata[B_PING] & wdata[B_WRAP] & ~wdata[B_M2M];
  assign start     = ctrl_wr & wdata[B_RUN] & ~run_q;
  assign start_tgt = ping_ok & wdata[B_FIRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      if (run_done) run_q <= 1'b0;
      if (ctrl_wr) begin
        run_q <= wdata[B_RUN];
        if (!run_q) begin
          mode_q.wrap <= wdata[B_WRAP];
          mode_q.ping <= ping_ok;
          mode_q.m2m  <= wdata[B_M2M];
          mode_q.sz   <= wdata[B_SZ_LO+1:B_SZ_LO];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr && (sel == SEL_COUNT)) cnt_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (|blk_vec) err_q <= 1'b1;
    else if (wr && (sel == SEL_ERR) && wdata[0]) err_q <= 1'b0;
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_base
    logic [AW-1:0] base_r;
    logic          hit;
    assign hit        = wr && (sel == 3'(int'(SEL_BASE0) + g));
    assign blk_vec[g] = hit && run_q && (cur_tgt == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_r <= '0;
      else if (hit && !blk_vec[g]) base_r <= wdata;
    end
    assign base[g] = base_r;
  end

  assign run  = run_q;
  assign mode = mode_q;
  assign cnt  = cnt_q;
  assign err  = err_q;

endmodule

// File: rtl/dbuf_walker.sv
module dbuf_walker
  import dbuf_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       start_tgt,
  input  logic [NUM_TGT-1:0][AW-1:0] base,
  input  logic [CW-1:0]              cnt,
  input  mode_t                      mode,
  input  logic                       fire,
  output logic [AW-1:0]              addr,
  output logic                       tgt,
  output logic                       sw,
  output logic                       done
);

  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;
  logic          tgt_q;
  logic          sw_q;
  logic          last;
  logic [AW-1:0] step;

  assign last = (rem_q <= CW'(1));
  assign step = AW'(step_bytes(mode.sz));
  assign done = fire && last && !mode.wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
      tgt_q  <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      sw_q <= 1'b0;
      if (start) begin
        tgt_q  <= start_tgt;
        addr_q <= base[start_tgt];
        rem_q  <= cnt;
      end else if (fire) begin
        if (last) begin
          rem_q <= cnt;
          if (mode.ping) begin
            tgt_q  <= ~tgt_q;
            addr_q <= base[~tgt_q];
            sw_q   <= 1'b1;
          end else begin
            addr_q <= base[tgt_q];
          end
        end else begin
          addr_q <= addr_q + step;
          rem_q  <= rem_q - CW'(1);
        end
      end
    end
  end

  assign addr = addr_q;
  assign tgt  = tgt_q;
  assign sw   = sw_q;

endmodule

// File: rtl/dbuf_addr_seq.sv
module dbuf_addr_seq
  import dbuf_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          beat_valid,
  output logic          beat_ready,
  output logic [AW-1:0] addr_o,
  output logic          cur_tgt,
  output logic          sw_pulse,
  output logic          run_o,
  output logic          dbuf_on,
  output logic          err_o
);

  logic                       run;
  mode_t                      mode;
  logic                       start;
  logic                       start_tgt;
  logic [NUM_TGT-1:0][AW-1:0] base;
  logic [CW-1:0]              cnt;
  logic                       err;
  logic                       fire;
  logic                       done;
  logic                       tgt;

  assign fire = beat_valid && run;

  dbuf_cfg_regs #(.AW(AW), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel), .wdata(cfg_wdata),
    .cur_tgt(tgt), .run_done(done), .run(run), .mode(mode), .start(start),
    .start_tgt(start_tgt), .base(base), .cnt(cnt), .err(err)
  );

  dbuf_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tgt(start_tgt),
    .base(base), .cnt(cnt), .mode(mode), .fire(fire),
    .addr(addr_o), .tgt(tgt), .sw(sw_pulse), .done(done)
  );

  assign beat_ready = run;
  assign cur_tgt    = tgt;
  assign run_o      = run;
  assign dbuf_on    = mode.ping;
  assign err_o      = err;

endmodule

// File: rtl/dbuf_addr_seq_chk.sv
module dbuf_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [2:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] addr_o,
  input logic          cur_tgt,
  input logic          sw_pulse,
  input logic          run_o,
  input logic          dbuf_on,
  input logic          err_o,
  input logic          wrap_i,
  input logic          m2m_i
);

  // R4
  tgt_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> (cur_tgt != $past(cur_tgt)));

  // R10
  pulse_needs_ping_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |-> dbuf_on);

  // R2 R3
  ping_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_on |-> (wrap_i && !m2m_i));

  // R6
  ping_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && $past(run_o)) |-> $stable(dbuf_on));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !beat_valid) |=> $stable(addr_o));

  // R11
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> !beat_ready);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_o) && !($past(cfg_wr) && ($past(cfg_sel) == 3'd4) && $past(cfg_wdata[0])))
      |-> err_o);

endmodule

bind dbuf_addr_seq dbuf_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_wdata(cfg_wdata), .beat_valid(beat_valid), .beat_ready(beat_ready),
  .addr_o(addr_o), .cur_tgt(cur_tgt), .sw_pulse(sw_pulse), .run_o(run_o),
  .dbuf_on(dbuf_on), .err_o(err_o), .wrap_i(mode.wrap), .m2m_i(mode.m2m)
);

// File: tb/sim_dbuf_addr_seq.sv
module sim_dbuf_addr_seq;
  localparam int AW = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_sel = 3'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          beat_valid = 1'b0;
  logic          beat_ready;
  logic [AW-1:0] addr_o;
  logic          cur_tgt;
  logic          sw_pulse;
  logic          run_o;
  logic          dbuf_on;
  logic          err_o;

  always #4 clk = ~clk;

  dbuf_addr_seq #(.AW(AW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .addr_o(addr_o), .cur_tgt(cur_tgt), .sw_pulse(sw_pulse), .run_o(run_o),
    .dbuf_on(dbuf_on), .err_o(err_o)
  );

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [AW:0] exp_q[$];
  logic [AW:0] mon_e;

  task automatic chk(input bit ok, input string tag, input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every accepted beat pops one expected {target, address}
  always @(negedge clk) begin
    if (rst_n) begin
      if (sw_pulse) pulses++;
      if (beat_valid && beat_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected beat", {cur_tgt, addr_o}, '0);
        end else begin
          mon_e = exp_q.pop_front();
          chk({cur_tgt, addr_o} == mon_e, "R4 R9 beat address", {cur_tgt, addr_o}, mon_e);
        end
      end
    end
  end

  function automatic logic [AW-1:0] ctrl(input bit run, input bit wrap, input bit ping,
                                         input bit m2m, input bit first, input logic [1:0] sz);
    ctrl = '0;
    ctrl[0] = run; ctrl[1] = wrap; ctrl[2] = ping; ctrl[3] = m2m; ctrl[4] = first;
    ctrl[6:5] = sz;
  endfunction

  task automatic cfg_write(input logic [2:0] sel, input logic [AW-1:0] data);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic push_block(input logic [AW-1:0] base, input int n, input int step, input bit tgt);
    for (int i = 0; i < n; i++) exp_q.push_back({tgt, base + AW'(i * step)});
  endtask

  task automatic run_beats(input int n);
    @(posedge clk); #1;
    beat_valid = 1'b1;
    repeat (n) @(posedge clk);
    #1 beat_valid = 1'b0;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk({run_o, beat_ready, dbuf_on, err_o, sw_pulse, cur_tgt} == 6'b0, "R1 reset flags",
        {run_o, beat_ready, dbuf_on, err_o, sw_pulse, cur_tgt}, 0);
    chk(addr_o == '0, "R1 reset addr", addr_o, 0);
    rst_n = 1'b1;

    cfg_write(3'd1, 32'h1000);
    cfg_write(3'd2, 32'h2000);
    cfg_write(3'd3, 32'd4);
    cfg_write(3'd0, ctrl(1, 1, 1, 0, 0, 2'd2));
    // R5 start on buffer 0
    chk(addr_o == 32'h1000 && cur_tgt == 1'b0, "R5 first buffer 0", {cur_tgt, addr_o}, {1'b0, 32'h1000});
    chk(dbuf_on == 1'b1, "R4 ping-pong accepted", dbuf_on, 1);

    // R4 R9: three blocks, 4-byte step
    push_block(32'h1000, 4, 4, 1'b0);
    push_block(32'h2000, 4, 4, 1'b1);
    push_block(32'h1000, 4, 4, 1'b0);
    run_beats(12);
    chk(pulses == 3, "R10 pulse per switch", pulses, 3);
    chk(cur_tgt == 1'b1 && addr_o == 32'h2000, "R4 alternation", {cur_tgt, addr_o}, {1'b1, 32'h2000});

    // R7 write active buffer base: blocked; idle buffer: taken
    cfg_write(3'd2, 32'h3000);
    chk(err_o == 1'b1, "R7 blocked write flags error", err_o, 1);
    cfg_write(3'd1, 32'h4000);
    // R6 mode write while running is ignored
    cfg_write(3'd0, ctrl(1, 1, 0, 0, 1, 2'd0));
    chk(dbuf_on == 1'b1 && run_o == 1'b1, "R6 mode frozen while running", {run_o, dbuf_on}, 2'b11);
    push_block(32'h2000, 4, 4, 1'b1);
    push_block(32'h4000, 4, 4, 1'b0);
    run_beats(8);
    chk(pulses == 5, "R10 pulse count after idle rewrite", pulses, 5);
    chk(addr_o == 32'h2000, "R7 active base unchanged", addr_o, 32'h2000);

    // R8 sticky error
    cfg_write(3'd4, 32'd0);
    chk(err_o == 1'b1, "R8 clear with bit0 low keeps error", err_o, 1);
    cfg_write(3'd4, 32'd1);
    chk(err_o == 1'b0, "R8 clear with bit0 high", err_o, 0);

    // R11 stop, beats ignored
    cfg_write(3'd0, ctrl(0, 1, 1, 0, 0, 2'd2));
    chk(run_o == 1'b0 && beat_ready == 1'b0, "R11 stopped not ready", {run_o, beat_ready}, 0);
    run_beats(3);
    chk(addr_o == 32'h2000, "R9 no beat no advance", addr_o, 32'h2000);

    // R5 start on buffer 1 with 2-byte step
    cfg_write(3'd0, ctrl(1, 1, 1, 0, 1, 2'd1));
    chk(cur_tgt == 1'b1 && addr_o == 32'h2000, "R5 first buffer 1", {cur_tgt, addr_o}, {1'b1, 32'h2000});
    push_block(32'h2000, 4, 2, 1'b1);
    push_block(32'h4000, 1, 2, 1'b0);
    run_beats(5);
    chk(pulses == 6, "R10 pulse count second run", pulses, 6);

    // R2 ping-pong without wrap: single buffer, self stop
    cfg_write(3'd0, ctrl(0, 0, 0, 0, 0, 2'd0));
    cfg_write(3'd0, ctrl(1, 0, 1, 0, 1, 2'd0));
    chk(dbuf_on == 1'b0, "R2 ping-pong without wrap rejected", dbuf_on, 0);
    chk(cur_tgt == 1'b0 && addr_o == 32'h4000, "R5 single buffer uses buffer 0", {cur_tgt, addr_o}, {1'b0, 32'h4000});
    push_block(32'h4000, 4, 1, 1'b0);
    run_beats(4);
    chk(run_o == 1'b0 && beat_ready == 1'b0, "R11 self stop after count", {run_o, beat_ready}, 0);

    // R3 ping-pong with memory-to-memory: single buffer wrap, same base reload
    cfg_write(3'd0, ctrl(1, 1, 1, 1, 1, 2'd0));
    chk(dbuf_on == 1'b0, "R3 ping-pong with m2m rejected", dbuf_on, 0);
    push_block(32'h4000, 4, 1, 1'b0);
    push_block(32'h4000, 2, 1, 1'b0);
    run_beats(6);
    chk(pulses == 6, "R10 no pulse in single-buffer wrap", pulses, 6);
    chk(run_o == 1'b1, "R11 wrap stream keeps running", run_o, 1);
    chk(exp_q.size() == 0, "R4 all expected beats seen", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule